// File: doc/BRIEF.md
# Configurable UART Transmit Path

This block turns characters written by a host into an asynchronous serial stream on a single line. Characters of up to nine bits go into a small first-in first-out store. The host can shrink the usable depth of that store at run time to any value from one to four entries. A shifter pulls one entry at a time and sends it as a frame: a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. The line rests high when no frame is being sent.

Bit timing comes from a tick input that pulses once per sixteenth of a bit. Every bit therefore lasts sixteen ticks. The block asks the host for more data while the store holds no more entries than a programmed threshold. When flow control is enabled, the clear-to-send input can hold off the start of a new frame, but a frame that has already begun always finishes. Register decoding, the rate generator and modem lines belong to the surrounding logic.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, `txd` is 1, `tx_empty` is 1, `full` is 0 and `req` is 1.
- R2: A frame starts with one low bit. The data bits follow, least significant first. `cfg_len` code c selects c+5 data bits for c = 0..4, and codes 5 to 7 select 9 bits. Each start, data and parity bit lasts 16 `tick16` pulses.
- R3: `cfg_par` selects the parity bit: 0 = none, 1 = odd (data ones plus parity bit is odd), 2 = even, 3 = always 1, 4 = always 0. Codes 5 to 7 behave as none.
- R4: `cfg_stop` sets the high stop period: 0 = 16 ticks, 1 = 24 ticks, 2 or 3 = 32 ticks.
- R5: If another character is waiting and sending is allowed when a stop period ends, the next start bit begins on that same tick, with no idle gap. The start-to-start spacing is then exactly 16·(1+bits+parity) plus the stop ticks.
- R6: `cfg_depth` code d gives a usable depth of d+1. `full` is 1 exactly while the stored count is at least d+1.
- R7: A write while `full` is 1 is dropped, and that character is never sent.
- R8: `req` is 1 exactly while the stored count is less than or equal to `cfg_thresh`.
- R9: When `cts_en` is 1 and `cts_n` is 1, no new frame starts and `txd` stays high. When `cts_en` is 0, `cts_n` has no effect.
- R10: A frame in progress completes in full even if `cts_n` rises during it.
- R11: `tx_empty` is 1 only when the store is empty and no frame is in progress.
- R12: Characters leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 9 | Character to queue |
| cfg_depth | input | 2 | Usable depth minus one |
| cfg_thresh | input | 3 | Request threshold on the stored count |
| cfg_len | input | 3 | Data-bit count code |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| cts_en | input | 1 | Enables flow control |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output line |
| full | output | 1 | Store at programmed depth |
| req | output | 1 | Host service request |
| tx_empty | output | 1 | Store and shifter both idle |

## Verification
The hardest case to reach is a flow-control change in the middle of a frame. The stimulus first stops the line with clear-to-send while characters wait in the store. It then releases the line, raises `cts_n` again forty cycles into the first frame, and checks that this frame finishes bit for bit while the next one stays queued. Exact back-to-back spacing is a second hard case. The bench measures it for every combination of length, parity and stop code by queuing two characters and timing the two falling edges.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    localparam int MIN_BITS = 5;
    localparam int TICKS_PER_BIT = 16;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int DW    = 9,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    input  logic [AW-1:0] cfg_depth,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_s;

    fifo_s q, d;
    logic  push;
    logic  do_pop;
    logic [CW-1:0] limit;

    assign limit  = CW'(cfg_depth) + CW'(1);
    assign full   = (q.cnt >= limit);
    assign empty  = (q.cnt == '0);
    assign level  = q.cnt;
    assign rdata  = q.mem[q.rp];
    assign push   = wr_en && !full;
    assign do_pop = pop && !empty;

    always_comb begin
        d = q;
        if (push) begin
            d.mem[q.wp] = wdata;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + AW'(1);
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + AW'(1);
        end
        case ({push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          can_go,
    input  logic [DW-1:0] data,
    input  logic [2:0]    cfg_len,
    input  logic [2:0]    cfg_par,
    input  logic [1:0]    cfg_stop,
    output logic          pop,
    output logic          txd,
    output logic          busy
);
    typedef struct packed {
        tx_state_e     st;
        logic [4:0]    cnt;
        logic [3:0]    idx;
        logic [DW-1:0] sh;
        logic          pbit;
        logic          txd;
    } shf_s;

    shf_s q, d;
    logic [3:0]    nbits;
    logic [DW-1:0] data_m;
    logic          par_on;
    logic          pbit_new;
    logic [4:0]    lim;
    logic          last;
    logic          load;

    assign nbits  = (cfg_len > 3'd4) ? 4'(DW) : 4'(cfg_len) + 4'(MIN_BITS);
    assign par_on = (cfg_par >= 3'd1) && (cfg_par <= 3'd4);

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            data_m[i] = data[i] && (i < int'(nbits));
        end
    end

    always_comb begin
        case (cfg_par)
            3'd1:    pbit_new = ~^data_m;
            3'd2:    pbit_new = ^data_m;
            3'd3:    pbit_new = 1'b1;
            default: pbit_new = 1'b0;
        endcase
    end

    always_comb begin
        if (q.st == ST_STOP) begin
            case (cfg_stop)
                2'd0:    lim = 5'd15;
                2'd1:    lim = 5'd23;
                default: lim = 5'd31;
            endcase
        end else begin
            lim = 5'(TICKS_PER_BIT - 1);
        end
    end

    assign last = tick && (q.cnt == lim);

    always_comb begin
        d    = q;
        load = 1'b0;
        if (tick && !last) begin
            d.cnt = q.cnt + 5'd1;
        end
        case (q.st)
            ST_IDLE: begin
                d.txd = 1'b1;
                d.cnt = '0;
                load  = tick && can_go;
            end
            ST_START: begin
                if (last) begin
                    d.st  = ST_DATA;
                    d.cnt = '0;
                    d.idx = '0;
                    d.txd = q.sh[0];
                end
            end
            ST_DATA: begin
                if (last) begin
                    d.cnt = '0;
                    if (q.idx == nbits - 4'd1) begin
                        d.st  = par_on ? ST_PAR : ST_STOP;
                        d.txd = par_on ? q.pbit : 1'b1;
                    end else begin
                        d.idx = q.idx + 4'd1;
                        d.sh  = q.sh >> 1;
                        d.txd = q.sh[1];
                    end
                end
            end
            ST_PAR: begin
                if (last) begin
                    d.st  = ST_STOP;
                    d.cnt = '0;
                    d.txd = 1'b1;
                end
            end
            ST_STOP: begin
                if (last) begin
                    d.cnt = '0;
                    d.st  = ST_IDLE;
                    d.txd = 1'b1;
                    load  = can_go;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (load) begin
            d.st   = ST_START;
            d.cnt  = '0;
            d.idx  = '0;
            d.sh   = data_m;
            d.pbit = pbit_new;
            d.txd  = 1'b0;
        end
        pop = load;
    end

    assign txd  = q.txd;
    assign busy = (q.st != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path #(
    parameter int DATA_W     = 9,
    parameter int FIFO_DEPTH = 4,
    localparam int PTR_W     = $clog2(FIFO_DEPTH),
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  cfg_depth,
    input  logic [LVL_W-1:0]  cfg_thresh,
    input  logic [2:0]        cfg_len,
    input  logic [2:0]        cfg_par,
    input  logic [1:0]        cfg_stop,
    input  logic              cts_en,
    input  logic              cts_n,
    output logic              txd,
    output logic              full,
    output logic              req,
    output logic              tx_empty
);
    logic [DATA_W-1:0] head;
    logic [LVL_W-1:0]  level;
    logic              empty;
    logic              pop;
    logic              busy;
    logic              cts_ok;

    assign cts_ok = !cts_en || !cts_n;

    tx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wdata     (wr_data),
        .pop       (pop),
        .cfg_depth (cfg_depth),
        .rdata     (head),
        .level     (level),
        .full      (full),
        .empty     (empty)
    );

    tx_shifter #(.DW(DATA_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .can_go   (!empty && cts_ok),
        .data     (head),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .cfg_stop (cfg_stop),
        .pop      (pop),
        .txd      (txd),
        .busy     (busy)
    );

    assign req      = (level <= cfg_thresh);
    assign tx_empty = empty && !busy;
endmodule

// File: rtl/tx_path_checker.sv
module tx_path_checker #(
    parameter int LW    = 3,
    parameter int DEPTH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          tx_empty,
    input logic          full,
    input logic          busy,
    input logic          wr_en,
    input logic          pop,
    input logic [LW-1:0] level,
    input logic          cts_en,
    input logic          cts_n
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH); // R6
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !pop) |=> (level == $past(level))); // R7
    AST_CTS_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cts_en && cts_n) |=> !busy); // R9
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2
    AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !full); // R6
endmodule

bind uart_tx_path tx_path_checker #(.LW(LVL_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .tx_empty (tx_empty),
    .full     (full),
    .busy     (busy),
    .wr_en    (wr_en),
    .pop      (pop),
    .level    (level),
    .cts_en   (cts_en),
    .cts_n    (cts_n)
);

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] cfg_depth = 2'd3;
    logic [2:0] cfg_thresh = 3'd0;
    logic [2:0] cfg_len = 3'd3;
    logic [2:0] cfg_par = 3'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       cts_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd, full, req, tx_empty;

    int n_chk = 0;
    int n_bad = 0;
    longint cyc = 0;

    uart_tx_path uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_depth(cfg_depth), .cfg_thresh(cfg_thresh), .cfg_len(cfg_len),
        .cfg_par(cfg_par), .cfg_stop(cfg_stop), .cts_en(cts_en), .cts_n(cts_n),
        .txd(txd), .full(full), .req(req), .tx_empty(tx_empty)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nbits_of(input int lc);
        return (lc > 4) ? 9 : lc + 5;
    endfunction

    function automatic int stop_ticks(input int sc);
        return (sc == 0) ? 16 : (sc == 1) ? 24 : 32;
    endfunction

    task automatic wr(input logic [8:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Receives one frame and checks start, data (R2), parity (R3) and stop level (R4).
    task automatic rx_frame(input logic [8:0] v, input string tag, output longint tfall);
        int nb;
        int pm;
        logic [8:0] m;
        logic pe;
        nb = nbits_of(int'(cfg_len));
        pm = int'(cfg_par);
        m = v & 9'((1 << nb) - 1);
        while (txd !== 1'b0) @(negedge clk);
        tfall = cyc;
        repeat (8) @(negedge clk);
        chk(txd == 1'b0, {tag, " R2 start"}, txd, 0);
        for (int i = 0; i < nb; i++) begin
            repeat (16) @(negedge clk);
            chk(txd == m[i], {tag, " R2 data/R12 order"}, txd, m[i]);
        end
        if (pm >= 1 && pm <= 4) begin
            case (pm)
                1: pe = ~(^m);
                2: pe = ^m;
                3: pe = 1'b1;
                default: pe = 1'b0;
            endcase
            repeat (16) @(negedge clk);
            chk(txd == pe, {tag, " R3 parity"}, txd, pe);
        end
        repeat (16) @(negedge clk);
        chk(txd == 1'b1, {tag, " R4 stop high"}, txd, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint t1, t2;
        int per;
        int bad_hold;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        chk(full == 1'b0, "R1 full", full, 0);
        chk(req == 1'b1, "R1 req", req, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5: sweep of length, parity and stop codes
        for (int lc = 0; lc < 6; lc++) begin
            for (int pm = 0; pm < 6; pm++) begin
                for (int sc = 0; sc < 4; sc++) begin
                    logic [8:0] a, b;
                    a = 9'(37 * (lc * 24 + pm * 4 + sc) + 9'h155);
                    b = ~a;
                    cfg_len = 3'(lc);
                    cfg_par = 3'(pm);
                    cfg_stop = 2'(sc);
                    wr(a);
                    wr(b);
                    rx_frame(a, "sweep a", t1);
                    rx_frame(b, "sweep b", t2);
                    per = 16 * (1 + nbits_of(lc) + ((pm >= 1 && pm <= 4) ? 1 : 0)) + stop_ticks(sc);
                    chk((t2 - t1) == per, "R5 start spacing / R4 stop length", t2 - t1, per);
                    repeat (stop_ticks(sc) - 8) @(negedge clk);
                    chk(tx_empty == 1'b1, "R11 empty after last stop", tx_empty, 1);
                end
            end
        end

        // R6 R7 R8 R12: depth codes, full flag, request threshold, dropped write
        cfg_len = 3'd3;
        cfg_par = 3'd0;
        cfg_stop = 2'd0;
        for (int dc = 0; dc < 4; dc++) begin
            cfg_depth = 2'(dc);
            cts_en = 1'b1;
            cts_n = 1'b1;
            for (int k = 0; k <= dc + 1; k++) begin
                if (k > 0) wr(9'(8'h30 + 8'(k) + 8'(dc * 16)));
                chk(full == (k >= dc + 1), "R6 full at depth", full, k >= dc + 1);
                for (int th = 0; th < 8; th++) begin
                    cfg_thresh = 3'(th);
                    #1;
                    chk(req == (k <= th), "R8 req threshold", req, k <= th);
                end
            end
            wr(9'h0EE);
            chk(full == 1'b1, "R7 still full after dropped write", full, 1);
            cts_n = 1'b0;
            for (int k = 1; k <= dc + 1; k++) begin
                rx_frame(9'(8'h30 + 8'(k) + 8'(dc * 16)), "R12 fifo order", t1);
            end
            repeat (40) @(negedge clk);
            chk(tx_empty == 1'b1, "R7 dropped char not sent", tx_empty, 1);
            chk(txd == 1'b1, "R7 line idle", txd, 1);
        end
        cfg_thresh = 3'd0;
        cfg_depth = 2'd3;

        // R9: hold while clear-to-send is inactive
        cts_en = 1'b1;
        cts_n = 1'b1;
        wr(9'h05A);
        wr(9'h0C3);
        bad_hold = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad_hold++;
        end
        chk(bad_hold == 0, "R9 line held high", bad_hold, 0);
        chk(tx_empty == 1'b0, "R9 data still queued", tx_empty, 0);

        // R10: frame completes even when clear-to-send drops mid-frame
        cts_n = 1'b0;
        fork
            rx_frame(9'h05A, "R10 frame completes", t1);
            begin
                repeat (40) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        bad_hold = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad_hold++;
        end
        chk(bad_hold == 0, "R10 next frame held", bad_hold, 0);
        chk(tx_empty == 1'b0, "R10 second char waiting", tx_empty, 0);

        // R9: flow control disabled ignores cts_n
        cts_en = 1'b0;
        rx_frame(9'h0C3, "R9 cts disabled", t1);
        repeat (16) @(negedge clk);
        chk(tx_empty == 1'b1, "R11 empty at end", tx_empty, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule